// File: doc/BRIEF.md
# Multi-Mode Timer Counter Core

This block is a parameterised timer counter, 16 bits wide by default. It counts against a programmable ceiling value (TOP). It has four counting modes. Up and down counting wrap at the ends of the range. Up/down counting runs as a triangle between 0 and TOP. The fourth mode follows a two-phase quadrature encoder at two or four counts per encoder period. In the three timed modes, a power-of-two clock-enable prescaler sets the pace of the count, from every cycle to every 1024th cycle.

Software start and stop inputs set whether the counter runs. Edges on a separate control input can do the same without software. The rising edge and the falling edge each have their own action code, which can start the counter, stop it, or reload it and start it. A single-run option stops the counter at its first wrap.

The control input and both encoder phases are asynchronous. Each passes through a two-flop synchronizer before its edges are detected. Overflow and underflow are reported as one-cycle pulses that are registered together with the new count.

The run control is a two-state machine. STOPPED moves to RUNNING on a start request when no stop request is present. RUNNING moves to STOPPED on any stop request, or on a wrap while single-run is selected. The up/down mode also uses a direction machine. RISING moves to FALLING at the top turnaround, FALLING moves to RISING at the bottom turnaround, and any reload returns it to RISING.

Top module: `mm_timer_core`

## Requirements
- R1: After reset, the count is 0, the counter is stopped, and both event pulses are low.
- R2: A software start pulse moves the counter to running without changing the count. A software stop pulse moves it to stopped. When start and stop are asserted together, stop wins.
- R3: In the timed modes (mode codes 0, 1 and 2), a prescale select k from 0 to 10 makes the count advance once every 2^k clock cycles while running. The first step comes 2^k cycles after the start edge. Any select value above 10 acts as 10.
- R4: Mode code 0 counts up. A step taken at a count of TOP or above loads 0 and pulses overflow.
- R5: Mode code 1 counts down. A step taken at a count of 0 loads TOP and pulses underflow.
- R6: Mode code 2 counts up/down. Rising, a step taken at TOP goes to TOP-1 with an overflow pulse. Falling, a step taken at 0 goes to 1 with an underflow pulse. The 0-to-1 step right after a start or reload gives no pulse.
- R7: Mode code 3 with four-count decoding selected takes one step on every single-phase transition of the synchronized encoder inputs. The sequence (A,B) 00, 10, 11, 01 counts up and the reverse sequence counts down. Counting up from TOP gives 0 with overflow, and counting down from 0 gives TOP with underflow. The prescaler is not used in this mode.
- R8: Mode code 3 with two-count decoding selected steps only on transitions of phase A while B holds, so one encoder period moves the count by 2. Transitions of B alone are ignored.
- R9: Each edge of the control input applies its own 2-bit action: 0 none, 1 start without reload, 2 stop, 3 reload and start. Reload loads TOP in mode code 1 and 0 in every other mode. A reload takes precedence over a step in the same cycle.
- R10: With single-run selected, the step that produces an overflow or underflow pulse also stops the counter, and the wrapped value is kept.
- R11: Overflow and underflow are never high together, and a pulse appears only after a cycle in which the counter was running.
- R12: While stopped, the count holds its value, including when the encoder phases move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Counting mode: 0 up, 1 down, 2 up/down, 3 quadrature |
| quad_x4_i | input | 1 | Quadrature resolution: 1 four counts per period, 0 two |
| top_i | input | CNT_W | Ceiling value TOP |
| presc_sel_i | input | PSEL_W | Prescale exponent (divide by 2^k, clamped at PRESC_MAX) |
| one_shot_i | input | 1 | Single-run: stop at the first wrap |
| sw_start_i | input | 1 | Software start request |
| sw_stop_i | input | 1 | Software stop request |
| qa_i | input | 1 | Encoder phase A, asynchronous |
| qb_i | input | 1 | Encoder phase B, asynchronous |
| ctl_i | input | 1 | Control input, asynchronous |
| ctl_rise_act_i | input | 2 | Action on a rising edge of the control input |
| ctl_fall_act_i | input | 2 | Action on a falling edge of the control input |
| count_o | output | CNT_W | Current count |
| running_o | output | 1 | Counter is running |
| ovf_o | output | 1 | One-cycle overflow pulse |
| udf_o | output | 1 | One-cycle underflow pulse |

## Verification
The hardest case to reach is the one-cycle underflow at the bottom of quadrature counting. It needs a reverse encoder step at exactly count 0. The stimulus gets there by driving one full forward period and then one full reverse period, which returns the count to 0. A single further reverse step then forces the wrap to TOP, and a forward step forces the wrap back to 0. Pulses are tallied by a negative-edge monitor so that a single-cycle event is never missed. The control-edge actions are exercised with the prescaler at its slowest setting, which freezes the count so that every reload, or the absence of one, can be seen exactly.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

    typedef enum logic [1:0] {
        CM_UP     = 2'd0,
        CM_DOWN   = 2'd1,
        CM_UPDOWN = 2'd2,
        CM_QUAD   = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        EA_NONE   = 2'd0,
        EA_START  = 2'd1,
        EA_STOP   = 2'd2,
        EA_RELOAD = 2'd3
    } edge_act_e;

    typedef enum logic {
        RS_STOPPED = 1'b0,
        RS_RUNNING = 1'b1
    } run_state_e;

    typedef enum logic {
        DIR_RISING  = 1'b0,
        DIR_FALLING = 1'b1
    } dir_state_e;

endpackage

// File: rtl/mmt_sync.sv
module mmt_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] prev_o
);
    // Per bit: two synchronizer stages plus one history stage.
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic s1_q, s2_q, s3_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
                s3_q <= 1'b0;
            end else begin
                s1_q <= async_i[g];
                s2_q <= s1_q;
                s3_q <= s2_q;
            end
        end
        assign level_o[g] = s2_q;
        assign prev_o[g]  = s3_q;
    end
endmodule

// File: rtl/mmt_prescaler.sv
module mmt_prescaler #(
    parameter int PRESC_MAX = 10,
    parameter int PSEL_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [PSEL_W-1:0] sel_i,
    output logic              tick_o
);
    localparam int PW = PRESC_MAX;

    logic [PW-1:0]     pcnt_q;
    logic [PSEL_W-1:0] sel_eff;
    logic [PW:0]       one_sh;
    logic [PW-1:0]     mask;

    always_comb begin
        sel_eff = (int'(sel_i) > PRESC_MAX) ? PSEL_W'(PRESC_MAX) : sel_i;
        one_sh  = (PW+1)'(1) << sel_eff;
        mask    = one_sh[PW-1:0] - PW'(1);
        tick_o  = run_i && ((pcnt_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pcnt_q <= '0;
        else if (!run_i) pcnt_q <= '0;
        else             pcnt_q <= pcnt_q + PW'(1);
    end
endmodule

// File: rtl/mmt_quad_dec.sv
module mmt_quad_dec (
    input  logic a_cur,
    input  logic b_cur,
    input  logic a_prev,
    input  logic b_prev,
    input  logic x4_i,
    output logic step_o,
    output logic up_o
);
    logic a_ch, b_ch;

    always_comb begin
        a_ch = a_cur ^ a_prev;
        b_ch = b_cur ^ b_prev;
        // Forward order 00 -> 10 -> 11 -> 01: the old A equals the new B.
        up_o = ~(a_prev ^ b_cur);
        if (x4_i) step_o = a_ch ^ b_ch;
        else      step_o = a_ch & ~b_ch;
    end
endmodule

// File: rtl/mm_timer_core.sv
module mm_timer_core
    import mmt_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int PRESC_MAX = 10,
    parameter int PSEL_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              quad_x4_i,
    input  logic [CNT_W-1:0]  top_i,
    input  logic [PSEL_W-1:0] presc_sel_i,
    input  logic              one_shot_i,
    input  logic              sw_start_i,
    input  logic              sw_stop_i,
    input  logic              qa_i,
    input  logic              qb_i,
    input  logic              ctl_i,
    input  logic [1:0]        ctl_rise_act_i,
    input  logic [1:0]        ctl_fall_act_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              running_o,
    output logic              ovf_o,
    output logic              udf_o
);
    localparam int          NSYNC = 3;
    localparam int          IDX_A = 0;
    localparam int          IDX_B = 1;
    localparam int          IDX_C = 2;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // ---------------- input conditioning ----------------
    logic [NSYNC-1:0] lvl, prv;

    mmt_sync #(.N(NSYNC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ctl_i, qb_i, qa_i}),
        .level_o (lvl),
        .prev_o  (prv)
    );

    logic ctl_rise, ctl_fall;
    assign ctl_rise = lvl[IDX_C] & ~prv[IDX_C];
    assign ctl_fall = ~lvl[IDX_C] & prv[IDX_C];

    logic q_step, q_up;
    mmt_quad_dec u_quad (
        .a_cur  (lvl[IDX_A]),
        .b_cur  (lvl[IDX_B]),
        .a_prev (prv[IDX_A]),
        .b_prev (prv[IDX_B]),
        .x4_i   (quad_x4_i),
        .step_o (q_step),
        .up_o   (q_up)
    );

    run_state_e run_q, run_nx;
    dir_state_e dir_q, dir_nx;

    logic tick;
    mmt_prescaler #(.PRESC_MAX(PRESC_MAX), .PSEL_W(PSEL_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (run_q == RS_RUNNING),
        .sel_i (presc_sel_i),
        .tick_o(tick)
    );

    // ---------------- request decoding ----------------
    edge_act_e act_r, act_f;
    logic req_start, req_stop, req_reload, do_reload;

    always_comb begin
        act_r = ctl_rise ? edge_act_e'(ctl_rise_act_i) : EA_NONE;
        act_f = ctl_fall ? edge_act_e'(ctl_fall_act_i) : EA_NONE;
        req_stop   = sw_stop_i || (act_r == EA_STOP) || (act_f == EA_STOP);
        req_reload = (act_r == EA_RELOAD) || (act_f == EA_RELOAD);
        req_start  = sw_start_i || req_reload ||
                     (act_r == EA_START) || (act_f == EA_START);
        // A stop request cancels a reload in the same cycle.
        do_reload  = req_reload && !req_stop;
    end

    // ---------------- counter datapath ----------------
    cnt_mode_e        mode;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic             ovf_nx, udf_nx, step_en, wrap_evt;

    always_comb begin
        mode    = cnt_mode_e'(mode_i);
        step_en = (run_q == RS_RUNNING) && ((mode == CM_QUAD) ? q_step : tick);
        cnt_nx  = cnt_q;
        dir_nx  = dir_q;
        ovf_nx  = 1'b0;
        udf_nx  = 1'b0;
        if (do_reload) begin
            cnt_nx = (mode == CM_DOWN) ? top_i : '0;
            dir_nx = DIR_RISING;
        end else if (step_en) begin
            unique case (mode)
                CM_UP: begin
                    if (cnt_q >= top_i) begin
                        cnt_nx = '0;
                        ovf_nx = 1'b1;
                    end else begin
                        cnt_nx = cnt_q + ONE;
                    end
                end
                CM_DOWN: begin
                    if (cnt_q == '0) begin
                        cnt_nx = top_i;
                        udf_nx = 1'b1;
                    end else begin
                        cnt_nx = cnt_q - ONE;
                    end
                end
                CM_UPDOWN: begin
                    if (top_i == '0) begin
                        cnt_nx = '0;
                    end else begin
                        unique case (dir_q)
                            DIR_RISING: begin
                                if (cnt_q >= top_i) begin
                                    cnt_nx = top_i - ONE;
                                    dir_nx = DIR_FALLING;
                                    ovf_nx = 1'b1;
                                end else begin
                                    cnt_nx = cnt_q + ONE;
                                end
                            end
                            DIR_FALLING: begin
                                if (cnt_q == '0) begin
                                    cnt_nx = ONE;
                                    dir_nx = DIR_RISING;
                                    udf_nx = 1'b1;
                                end else begin
                                    cnt_nx = cnt_q - ONE;
                                end
                            end
                        endcase
                    end
                end
                CM_QUAD: begin
                    if (q_up) begin
                        if (cnt_q >= top_i) begin
                            cnt_nx = '0;
                            ovf_nx = 1'b1;
                        end else begin
                            cnt_nx = cnt_q + ONE;
                        end
                    end else begin
                        if (cnt_q == '0) begin
                            cnt_nx = top_i;
                            udf_nx = 1'b1;
                        end else begin
                            cnt_nx = cnt_q - ONE;
                        end
                    end
                end
            endcase
        end
        wrap_evt = ovf_nx || udf_nx;
    end

    // ---------------- run control FSM ----------------
    always_comb begin
        run_nx = run_q;
        unique case (run_q)
            RS_STOPPED: if (req_start && !req_stop) run_nx = RS_RUNNING;
            RS_RUNNING: if (req_stop || (one_shot_i && wrap_evt)) run_nx = RS_STOPPED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= RS_STOPPED;
            dir_q <= DIR_RISING;
        end else begin
            run_q <= run_nx;
            dir_q <= dir_nx;
        end
    end

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_o <= 1'b0;
            udf_o <= 1'b0;
        end else begin
            cnt_q <= cnt_nx;
            ovf_o <= ovf_nx;
            udf_o <= udf_nx;
        end
    end

    assign count_o   = cnt_q;
    assign running_o = (run_q == RS_RUNNING);

endmodule

// File: rtl/mmt_checker.sv
module mmt_checker
    import mmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_i,
    input logic [CNT_W-1:0] top_i,
    input logic             one_shot_i,
    input logic [CNT_W-1:0] count_o,
    input logic             running_o,
    input logic             ovf_o,
    input logic             udf_o
);
    // R11
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_o && udf_o));

    // R11
    pulse_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o || udf_o) |-> $past(running_o));

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && !$past(running_o)) |-> $stable(count_o));

    // R4
    up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && $past(mode_i) == CM_UP) |-> count_o == '0);

    // R5
    down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (udf_o && $past(mode_i) == CM_DOWN) |-> count_o == $past(top_i));

    // R6
    ud_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (udf_o && $past(mode_i) == CM_UPDOWN) |-> count_o == CNT_W'(1));

    // R10
    one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovf_o || udf_o) && $past(one_shot_i)) |-> !running_o);

endmodule

bind mm_timer_core mmt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .top_i     (top_i),
    .one_shot_i(one_shot_i),
    .count_o   (count_o),
    .running_o (running_o),
    .ovf_o     (ovf_o),
    .udf_o     (udf_o)
);

// File: tb/mm_timer_core_bench.sv
module mm_timer_core_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, x4, oneshot, sw_start, sw_stop, qa, qb, ctl;
    logic [1:0]  mode, ract, fact;
    logic [15:0] top;
    logic [3:0]  psel;
    logic [15:0] count;
    logic        running, ovf, udf;

    int n_chk = 0, n_fail = 0;
    int ovf_seen = 0, udf_seen = 0;
    bit wd_hit = 0;

    mm_timer_core u_mm_timer_core (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .quad_x4_i(x4), .top_i(top),
        .presc_sel_i(psel), .one_shot_i(oneshot), .sw_start_i(sw_start),
        .sw_stop_i(sw_stop), .qa_i(qa), .qb_i(qb), .ctl_i(ctl),
        .ctl_rise_act_i(ract), .ctl_fall_act_i(fact),
        .count_o(count), .running_o(running), .ovf_o(ovf), .udf_o(udf)
    );

    always @(negedge clk) if (rst_n) begin
        if (ovf) ovf_seen++;
        if (udf) udf_seen++;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; mode = 2'd0; x4 = 1; top = 16'd3; psel = 4'd0; oneshot = 0;
        sw_start = 0; sw_stop = 0; qa = 0; qb = 0; ctl = 0; ract = 0; fact = 0;
        cyc(3);
        rst_n = 1;
        cyc(1);
    endtask

    task automatic pulse_start();
        sw_start = 1; cyc(1); sw_start = 0;
    endtask

    task automatic pulse_stop();
        sw_stop = 1; cyc(1); sw_stop = 0;
    endtask

    task automatic qset(input logic a, input logic b);
        qa = a; qb = b; cyc(4);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 count", int'(count), 0);
        check("R1 running", int'(running), 0);
        check("R1 pulses", int'(ovf) + int'(udf), 0);
    endtask

    task automatic t_up();
        int base, c;
        do_reset();
        base = ovf_seen;
        pulse_start();
        check("R2 start keeps count", int'(count), 0);
        check("R2 running", int'(running), 1);
        for (int i = 1; i <= 8; i++) begin
            cyc(1);
            check("R4 up count", int'(count), i % 4);
            check("R4 ovf pulse", int'(ovf), (i % 4 == 0) ? 1 : 0);
        end
        cyc(1);
        check("R11 ovf pulse total", ovf_seen - base, 2);
        pulse_stop();
        c = int'(count);
        check("R2 stopped", int'(running), 0);
        cyc(5);
        check("R12 hold while stopped", int'(count), c);
        pulse_start();
        cyc(1);
        check("R2 restart without reload", int'(count), c + 1);
        pulse_stop();
        sw_start = 1; sw_stop = 1; cyc(1); sw_start = 0; sw_stop = 0;
        cyc(2);
        check("R2 stop wins", int'(running), 0);
    endtask

    task automatic t_down();
        do_reset();
        mode = 2'd1;
        pulse_start();
        for (int i = 1; i <= 8; i++) begin
            cyc(1);
            check("R5 down count", int'(count), (4 - (i % 4)) % 4);
            check("R5 udf pulse", int'(udf), (i % 4 == 1) ? 1 : 0);
        end
    endtask

    task automatic t_updown();
        int vals[6] = '{1, 2, 3, 2, 1, 0};
        do_reset();
        mode = 2'd2;
        pulse_start();
        for (int i = 1; i <= 13; i++) begin
            int p;
            p = (i - 1) % 6;
            cyc(1);
            check("R6 updown count", int'(count), vals[p]);
            check("R6 ovf at top", int'(ovf), (p == 3) ? 1 : 0);
            check("R6 udf at bottom", int'(udf), (p == 0 && i > 1) ? 1 : 0);
        end
    endtask

    task automatic t_presc();
        do_reset();
        top = 16'd1000; psel = 4'd2;
        pulse_start();
        cyc(3);
        check("R3 div4 before tick", int'(count), 0);
        cyc(1);
        check("R3 div4 first tick", int'(count), 1);
        cyc(4);
        check("R3 div4 second tick", int'(count), 2);
        do_reset();
        top = 16'd1000; psel = 4'd15;
        pulse_start();
        cyc(1023);
        check("R3 clamp before tick", int'(count), 0);
        cyc(1);
        check("R3 clamp tick", int'(count), 1);
    endtask

    task automatic t_quad4();
        int bo, bu;
        do_reset();
        mode = 2'd3; x4 = 1; top = 16'd100; psel = 4'd10;
        pulse_start();
        qset(1, 0); qset(1, 1); qset(0, 1); qset(0, 0);
        check("R7 x4 forward period", int'(count), 4);
        qset(0, 1); qset(1, 1); qset(1, 0); qset(0, 0);
        check("R7 x4 reverse period", int'(count), 0);
        bu = udf_seen; bo = ovf_seen;
        qset(0, 1);
        check("R7 x4 wrap down to TOP", int'(count), 100);
        check("R7 x4 udf pulse", udf_seen - bu, 1);
        qset(0, 0);
        check("R7 x4 wrap up to 0", int'(count), 0);
        check("R7 x4 ovf pulse", ovf_seen - bo, 1);
    endtask

    task automatic t_quad2();
        do_reset();
        mode = 2'd3; x4 = 0; top = 16'd100;
        pulse_start();
        qset(1, 0);
        check("R8 x2 A edge counts", int'(count), 1);
        qset(1, 1);
        check("R8 x2 B edge ignored", int'(count), 1);
        qset(0, 1); qset(0, 0);
        check("R8 x2 forward period", int'(count), 2);
        qset(0, 1); qset(1, 1); qset(1, 0); qset(0, 0);
        check("R8 x2 reverse period", int'(count), 0);
        qset(1, 0);
        pulse_stop();
        qset(1, 1); qset(0, 1); qset(0, 0); qset(1, 0);
        check("R12 quad ignored while stopped", int'(count), 1);
    endtask

    task automatic t_ctl();
        do_reset();
        mode = 2'd1; top = 16'd50; psel = 4'd10;
        ract = 2'd3; fact = 2'd2;
        ctl = 1; cyc(4);
        check("R9 rise reload running", int'(running), 1);
        check("R9 down reload to TOP", int'(count), 50);
        ctl = 0; cyc(4);
        check("R9 fall stop", int'(running), 0);
        check("R9 stop keeps count", int'(count), 50);
        ract = 2'd1; fact = 2'd0;
        ctl = 1; cyc(4);
        check("R9 rise start", int'(running), 1);
        check("R9 start no reload", int'(count), 50);
        ctl = 0; cyc(4);
        check("R9 fall none", int'(running), 1);
        ract = 2'd0;
        ctl = 1; cyc(4);
        check("R9 rise none count", int'(count), 50);
        mode = 2'd0; ract = 2'd3;
        ctl = 0; cyc(4);
        ctl = 1; cyc(4);
        check("R9 up reload to 0", int'(count), 0);
        check("R9 up reload running", int'(running), 1);
    endtask

    task automatic t_oneshot();
        int base;
        do_reset();
        oneshot = 1;
        base = ovf_seen;
        pulse_start();
        cyc(4);
        check("R10 wrapped value kept", int'(count), 0);
        check("R10 stopped at wrap", int'(running), 0);
        cyc(5);
        check("R10 stays at 0", int'(count), 0);
        check("R10 single ovf", ovf_seen - base, 1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_up();
                t_down();
                t_updown();
                t_presc();
                t_quad4();
                t_quad2();
                t_ctl();
                t_oneshot();
            end
            begin
                #(20 * 150000);
                wd_hit = 1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule